// File: doc/BRIEF.md
# Dual-Clock FIFO with Early-Warning Levels

This block queues data words between two unrelated clock domains. A producer pushes a word on any write-clock edge where its push request is high and the queue is not full; a consumer pops on any read-clock edge where its pop request is high and the queue is not empty. Words leave in the order they arrived. The two clocks are free-running and need no fixed phase or frequency relation.

Each side sees two status outputs, and all of them come from registers in that side's own clock domain. The write side sees `wr_full` and an early-warning level `wr_near_full`. The read side sees `rd_empty` and an early-warning level `rd_near_empty`. The warning levels are set by parameters. A push into a full queue and a pop from an empty queue do nothing. The word size and the depth come as a set, chosen by a single geometry parameter.

Top module: `dcfifo_top`

## Requirements
- R1: After both resets have been held low for at least three clocks of their own domain, `rd_empty`=1, `rd_near_empty`=1, `wr_full`=0 and `wr_near_full`=0.
- R2: Words are popped in the order they were accepted. `rd_data` takes the popped word on the read-clock edge that accepts the pop, and keeps that value until the next accepted pop.
- R3: A push while `wr_full`=1 stores nothing and does not move the write pointer. The word never comes out of the queue.
- R4: A pop while `rd_empty`=1 does not change `rd_data` and does not move the read pointer. The next word written is still the next word read.
- R5: `wr_full` rises on the write-clock edge that accepts the DEPTH-th stored word, so the queue holds exactly DEPTH words.
- R6: `rd_empty` rises on the read-clock edge that pops the last stored word.
- R7: Once both domains have been idle for several cycles, `wr_near_full` = (occupancy >= NEAR_FULL_LVL). `wr_full`=1 always implies `wr_near_full`=1.
- R8: Once both domains have been idle for several cycles, `rd_near_empty` = (occupancy <= NEAR_EMPTY_LVL). `rd_empty`=1 always implies `rd_near_empty`=1.
- R9: GEOMETRY selects words × bits as follows: 0 = 4096×4, 1 = 2048×9, 2 = 1024×18, 3 = 512×36. The default is 3.
- R10: Each pointer crosses domains in Gray code, which changes by at most one bit per edge. After the first push into an empty queue, `rd_empty` falls within 6 read clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, write domain |
| wr_en | input | 1 | Push request |
| wr_data | input | DATA_W | Word to push |
| wr_full | output | 1 | Queue holds DEPTH words |
| wr_near_full | output | 1 | Occupancy at or above NEAR_FULL_LVL |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, read domain |
| rd_en | input | 1 | Pop request |
| rd_data | output | DATA_W | Last popped word |
| rd_empty | output | 1 | Queue holds no words |
| rd_near_empty | output | 1 | Occupancy at or below NEAR_EMPTY_LVL |

## Verification
A single push into an empty queue measures how long the write pointer takes to cross to the read side. Pops issued against an empty queue separate an ignored request from a pointer that slips. Stepping the occupancy one word at a time across NEAR_EMPTY_LVL and NEAR_FULL_LVL tests each compare for an off-by-one error. A fill that runs past DEPTH, followed by a complete drain, shows the exact full boundary, shows that the writes made while full were dropped, and checks that the data order survives a pointer wrap.

// File: rtl/dcfifo_pkg.sv
// Package: geometry table and Gray-code helpers shared by the FIFO modules.
// Assumes GEOMETRY is within 0..3.
package dcfifo_pkg;

    // Address bits for each geometry index.
    function automatic int geo_addr_w(input int g);
        return 12 - g;
    endfunction

    // Word width for each geometry index.
    function automatic int geo_data_w(input int g);
        case (g)
            0:       return 4;
            1:       return 9;
            2:       return 18;
            default: return 36;
        endcase
    endfunction

endpackage

// File: rtl/dcfifo_sync.sv
// Two-stage synchroniser for a Gray-coded pointer.
// Assumes the input changes by at most one bit per source clock edge.
module dcfifo_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two flops in series into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctl.sv
// Write-side control: holds the write pointer, registers full and near-full.
// Assumes the read pointer arrives already synchronised, in Gray code.
module dcfifo_wr_ctl #(
    parameter int ADDR_W        = 9,
    parameter int NEAR_FULL_LVL = 500
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [ADDR_W:0] rgray_s,
    output logic [ADDR_W:0] wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic            push,
    output logic            full,
    output logic            near_full
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s, occ_nx;

    assign push  = wr_en && !full;
    assign waddr = wbin[ADDR_W-1:0];

    // Next pointer, its Gray form, and the occupancy it produces.
    always_comb begin
        wbin_nx  = wbin + PW'(push);
        wgray_nx = wbin_nx ^ (wbin_nx >> 1);
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_s >> i);
        occ_nx   = wbin_nx - rbin_s;
    end

    // Pointer and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin      <= '0;
            wgray     <= '0;
            full      <= 1'b0;
            near_full <= 1'b0;
        end else begin
            wbin      <= wbin_nx;
            wgray     <= wgray_nx;
            full      <= (wgray_nx == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
            near_full <= (int'(occ_nx) >= NEAR_FULL_LVL);
        end
    end

    p_hold_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wbin));
    p_gray_one_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
    p_full_implies_near_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> near_full);
endmodule

// File: rtl/dcfifo_rd_ctl.sv
// Read-side control: holds the read pointer, registers empty and near-empty.
// Assumes the write pointer arrives already synchronised, in Gray code.
module dcfifo_rd_ctl #(
    parameter int ADDR_W         = 9,
    parameter int NEAR_EMPTY_LVL = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic [ADDR_W:0] wgray_s,
    output logic [ADDR_W:0] rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic            pop,
    output logic            empty,
    output logic            near_empty
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, occ_nx;

    assign pop   = rd_en && !empty;
    assign raddr = rbin[ADDR_W-1:0];

    // Next pointer, its Gray form, and the occupancy it leaves behind.
    always_comb begin
        rbin_nx  = rbin + PW'(pop);
        rgray_nx = rbin_nx ^ (rbin_nx >> 1);
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_s >> i);
        occ_nx   = wbin_s - rbin_nx;
    end

    // Pointer and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin       <= '0;
            rgray      <= '0;
            empty      <= 1'b1;
            near_empty <= 1'b1;
        end else begin
            rbin       <= rbin_nx;
            rgray      <= rgray_nx;
            empty      <= (rgray_nx == wgray_s);
            near_empty <= (int'(occ_nx) <= NEAR_EMPTY_LVL);
        end
    end

    p_hold_when_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rbin));
    p_empty_implies_near_r8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> near_empty);
endmodule

// File: rtl/dcfifo_ram.sv
// Storage array: one write port on the write clock and one registered read
// port on the read clock. The read register holds its value between pops.
module dcfifo_ram #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 36
) (
    input  logic              wclk,
    input  logic              push,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              pop,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [1<<ADDR_W];

    // Store the pushed word.
    always_ff @(posedge wclk) begin
        if (push) mem[waddr] <= wdata;
    end

    // Load the output register only when a pop is accepted.
    always_ff @(posedge rclk) begin
        if (!rrst_n)  rdata <= '0;
        else if (pop) rdata <= mem[raddr];
    end

    p_data_hold_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
        !pop |=> $stable(rdata));
endmodule

// File: rtl/dcfifo_top.sv
// Dual-clock FIFO top. It ties together the two control sides, the pointer
// synchronisers and the storage array.
// Assumes 0 < NEAR_EMPTY_LVL and NEAR_FULL_LVL <= DEPTH.
module dcfifo_top #(
    parameter int GEOMETRY       = 3,
    parameter int NEAR_FULL_LVL  = 500,
    parameter int NEAR_EMPTY_LVL = 8,
    localparam int ADDR_W = dcfifo_pkg::geo_addr_w(GEOMETRY),
    localparam int DATA_W = dcfifo_pkg::geo_data_w(GEOMETRY)
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_near_full,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty,
    output logic              rd_near_empty
);
    logic [ADDR_W:0]   wgray, rgray, wgray_s, rgray_s;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              push, pop;

    dcfifo_wr_ctl #(.ADDR_W(ADDR_W), .NEAR_FULL_LVL(NEAR_FULL_LVL)) wr_i (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .rgray_s(rgray_s),
        .wgray(wgray), .waddr(waddr), .push(push),
        .full(wr_full), .near_full(wr_near_full));

    dcfifo_rd_ctl #(.ADDR_W(ADDR_W), .NEAR_EMPTY_LVL(NEAR_EMPTY_LVL)) rd_i (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .wgray_s(wgray_s),
        .rgray(rgray), .raddr(raddr), .pop(pop),
        .empty(rd_empty), .near_empty(rd_near_empty));

    dcfifo_sync #(.W(ADDR_W+1)) w2r_i (.clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));
    dcfifo_sync #(.W(ADDR_W+1)) r2w_i (.clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));

    dcfifo_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
        .wclk(wr_clk), .push(push), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .rrst_n(rd_rst_n), .pop(pop), .raddr(raddr), .rdata(rd_data));
endmodule

// File: tb/dcfifo_top_tb_top.sv
// Directed bench for dcfifo_top at its default geometry (512 x 36).
module dcfifo_top_tb_top;
    localparam int DW    = 36;
    localparam int DEPTH = 512;
    localparam int NF    = 500;
    localparam int NE    = 8;

    logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
    logic wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic wr_full, wr_near_full, rd_empty, rd_near_empty;

    int n_chk = 0, n_bad = 0, seq = 0;
    logic [DW-1:0] sb [$];

    always #2   wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    dcfifo_top dut_i (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .wr_near_full(wr_near_full),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en), .rd_data(rd_data),
        .rd_empty(rd_empty), .rd_near_empty(rd_near_empty));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pattern(input int i);
        return {4'h5, 32'(i) * 32'h9E3779B1};
    endfunction

    // One push attempt; the bench queues the word only if full was low.
    task automatic push_word(output bit acc);
        logic [DW-1:0] d;
        d = pattern(seq++);
        @(negedge wr_clk);
        acc = !wr_full;
        wr_en = 1; wr_data = d;
        @(negedge wr_clk);
        wr_en = 0;
        if (acc) sb.push_back(d);
    endtask

    // One pop attempt; compares rd_data when the pop was accepted.
    task automatic pop_word(output bit acc, input string req);
        logic [DW-1:0] e;
        @(negedge rd_clk);
        acc = !rd_empty;
        rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        if (acc) begin
            e = sb.pop_front();
            check(rd_data == e, req, 64'(rd_data), 64'(e));
        end
    endtask

    task automatic settle();
        repeat (12) @(negedge rd_clk);
        repeat (12) @(negedge wr_clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge rd_clk);
        wr_rst_n = 1; rd_rst_n = 1;
        @(negedge rd_clk); @(negedge wr_clk);
        check(rd_empty == 1,      "R1 empty",      64'(rd_empty), 1);
        check(rd_near_empty == 1, "R1 near_empty", 64'(rd_near_empty), 1);
        check(wr_full == 0,       "R1 full",       64'(wr_full), 0);
        check(wr_near_full == 0,  "R1 near_full",  64'(wr_near_full), 0);
        check($bits(rd_data) == DW, "R9 width", 64'($bits(rd_data)), DW);
    endtask

    task automatic t_single();
        bit a; int n;
        push_word(a);
        n = 0;
        while (rd_empty && n < 20) begin @(negedge rd_clk); n++; end
        check(n <= 6, "R10 empty clears", 64'(n), 6);
        pop_word(a, "R2 single word");
        check(rd_empty == 1, "R6 empty after last pop", 64'(rd_empty), 1);
    endtask

    task automatic t_empty_read();
        bit a; logic [DW-1:0] held;
        settle();
        held = rd_data;
        for (int i = 0; i < 3; i++) begin
            pop_word(a, "R4 unexpected pop");
            check(!a && rd_data == held, "R4 rd_data held", 64'(rd_data), 64'(held));
        end
        push_word(a);
        settle();
        pop_word(a, "R4 next word after ignored pops");
    endtask

    task automatic t_near_empty();
        bit a;
        for (int i = 0; i < NE; i++) push_word(a);
        settle();
        check(rd_near_empty == 1, "R8 at level", 64'(rd_near_empty), 1);
        push_word(a);
        settle();
        check(rd_near_empty == 0, "R8 above level", 64'(rd_near_empty), 0);
    endtask

    task automatic t_near_full();
        bit a;
        while (sb.size() < NF - 1) push_word(a);
        settle();
        check(wr_near_full == 0, "R7 below level", 64'(wr_near_full), 0);
        push_word(a);
        settle();
        check(wr_near_full == 1, "R7 at level", 64'(wr_near_full), 1);
        pop_word(a, "R2 mid-stream pop");
        settle();
        check(wr_near_full == 0, "R7 back below", 64'(wr_near_full), 0);
    endtask

    task automatic t_fill_drain();
        bit a; int bad_acc = 0, guard = 0;
        settle();
        for (int i = 0; i < DEPTH + 8; i++) begin
            bit exp_acc;
            exp_acc = (sb.size() < DEPTH);
            push_word(a);
            if (a != exp_acc) bad_acc++;
        end
        check(bad_acc == 0, "R5 accepts exactly DEPTH", 64'(bad_acc), 0);
        check(wr_full == 1 && sb.size() == DEPTH, "R5 full at DEPTH", 64'(sb.size()), DEPTH);
        settle();
        while (sb.size() > 0 && guard < 3 * DEPTH) begin
            pop_word(a, "R3 drain order, dropped writes absent");
            guard++;
        end
        check(rd_empty == 1, "R6 empty after drain", 64'(rd_empty), 1);
        check(sb.size() == 0, "R2 all words drained", 64'(sb.size()), 0);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_single();
        t_empty_read();
        t_near_empty();
        t_near_full();
        t_fill_drain();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule